// File: doc/BRIEF.md
# Frame-Synchronous Register Context Sequencer

This block keeps several banks of readout parameters (contexts) for an image sensor's timing logic and hands one of them to that logic per frame. A host port fills the banks one field at a time. A single command starts an automatic sequence: on each frame-start pulse the next programmed bank is copied into the active parameter register. Each field is a generic word, such as a window origin, a window size or an exposure length. Copying only on the frame-start pulse keeps every frame free of mixed settings.

The bank storage acts as the shadow copy of every context. The active register is updated from that storage only on a frame-start pulse. A host write to the bank currently in use is therefore held back until that bank is next loaded. Commands can arrive at any time. They are latched and take effect at the next frame boundary.

The controller has three named states. `ST_IDLE` (no sequence) keeps reloading context 0. `ST_RUN` steps one context per frame. `ST_HOLD` means a non-repeating sequence has reached its last context and stays there. The transitions, all taken on a frame-start pulse, are:

- start: any state to `ST_RUN`, or to `ST_HOLD` when the sequence has one context and no repeat.
- advance: `ST_RUN` to `ST_RUN`.
- finish: `ST_RUN` to `ST_HOLD` when the last context of a non-repeating sequence is loaded.
- stop: any state to `ST_IDLE`.
- reload: `ST_IDLE` or `ST_HOLD` stays where it is.

Top module: `ctx_sequencer`

## Requirements
- R1: After reset `active_ctx` is 0, `seq_running` is 0 and every bit of `active_params` is 0. All bank fields also reset to 0.
- R2: A host write with `wr_en`=1 and `wr_ctx` < NUM_CTX stores `wr_data` into field `wr_field` of bank `wr_ctx`. A write with `wr_ctx` >= NUM_CTX changes no bank.
- R3: `active_params` and `active_ctx` change only in the cycle after a `frame_start` pulse. Field f of `active_params` occupies bits [f*FIELD_W +: FIELD_W] and equals field f of the bank named by the new `active_ctx`, with the bank contents taken as they were before that edge.
- R4: A host write to the bank currently shown leaves `active_params` unchanged until the next `frame_start` that loads that bank.
- R5: A start command (`cmd_valid`=1, `cmd_stop`=0) with `cmd_count` from 1 to NUM_CTX is latched. At the next `frame_start` it loads context 0. A start command with `cmd_count` of 0 or above NUM_CTX is ignored.
- R6: While a sequence runs, each `frame_start` advances `active_ctx` by one, giving 0, 1, …, count-1.
- R7: With `cmd_repeat`=1, the `frame_start` after context count-1 loads context 0 and the sequence keeps going.
- R8: With `cmd_repeat`=0, once context count-1 is loaded every later `frame_start` reloads that same context.
- R9: A stop command (`cmd_valid`=1, `cmd_stop`=1) makes the next `frame_start` load context 0 and return to idle.
- R10: `seq_running` is 1 from the frame that starts a sequence until a non-repeating sequence loads its last context, or until a stop takes effect. Otherwise it is 0.
- R11: When several valid commands arrive before one `frame_start`, only the latest takes effect. A command arriving in the same cycle as `frame_start` waits for the following one.
- R12: In idle, and while holding, each `frame_start` reloads the current bank, so host writes to that bank become visible then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| wr_en | input | 1 | Host bank write strobe |
| wr_ctx | input | CTX_W (2) | Bank selected for the write |
| wr_field | input | FLD_W (2) | Field selected within the bank |
| wr_data | input | FIELD_W (16) | Value written |
| cmd_valid | input | 1 | Command strobe |
| cmd_stop | input | 1 | 1 = stop command, 0 = start command |
| cmd_count | input | CNT_W (2) | Number of contexts in the sequence |
| cmd_repeat | input | 1 | 1 = wrap to context 0 after the last context |
| active_params | output | NUM_FIELDS*FIELD_W (64) | Parameter set applied to the current frame |
| active_ctx | output | CTX_W (2) | Index of the applied context |
| seq_running | output | 1 | Sequence running |

## Verification
Directed cases cover five situations:
- a repeating three-context sequence, which shows the step order and the wrap to context 0;
- a two-context non-repeating sequence, which shows the hold on the last context and the drop of `seq_running`;
- a stop that lands in the middle of a sequence;
- a start with a count of zero;
- two commands sent back to back before one frame boundary.

Writes to the active bank in the middle of a frame tell shadowed updates apart from immediate ones. A write aimed at a bank index that does not exist is checked to leave every bank unchanged. After these, a long random mix of writes, commands and frame pulses, including ones that coincide in the same cycle, is compared every cycle against a bench model. That comparison separates the same-cycle ordering of a load, a write and a command latch.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ctx_bank_store.sv
module ctx_bank_store #(
    parameter int NUM_CTX    = 3,
    parameter int NUM_FIELDS = 4,
    parameter int FIELD_W    = 16,
    parameter int CTX_W      = 2,
    parameter int FLD_W      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CTX_W-1:0]              wr_ctx,
    input  logic [FLD_W-1:0]              wr_field,
    input  logic [FIELD_W-1:0]            wr_data,
    input  logic [CTX_W-1:0]              rd_ctx,
    output logic [NUM_FIELDS*FIELD_W-1:0] rd_params
);
    logic [NUM_FIELDS*FIELD_W-1:0] bank_q [NUM_CTX];

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_bank
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q[c][f*FIELD_W +: FIELD_W] <= '0;
                end else if (wr_en && (wr_ctx == CTX_W'(c))
                             && (wr_field == FLD_W'(f))) begin
                    bank_q[c][f*FIELD_W +: FIELD_W] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_params = bank_q[0];
        for (int c = 1; c < NUM_CTX; c++) begin
            if (rd_ctx == CTX_W'(c)) rd_params = bank_q[c];
        end
    end

    assert_rd_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctx < CTX_W'(NUM_CTX));
endmodule

// File: rtl/ctx_cmd_latch.sv
module ctx_cmd_latch #(
    parameter int NUM_CTX = 3,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             cmd_valid,
    input  logic             cmd_stop,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             cmd_repeat,
    output logic             pend_valid,
    output logic             pend_stop,
    output logic [CNT_W-1:0] pend_count,
    output logic             pend_repeat
);
    logic cmd_ok;

    always_comb begin
        cmd_ok = cmd_valid && (cmd_stop ||
                 ((cmd_count != '0) && (cmd_count <= CNT_W'(NUM_CTX))));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid  <= 1'b0;
            pend_stop   <= 1'b0;
            pend_count  <= '0;
            pend_repeat <= 1'b0;
        end else if (cmd_ok) begin
            pend_valid  <= 1'b1;
            pend_stop   <= cmd_stop;
            pend_count  <= cmd_count;
            pend_repeat <= cmd_repeat;
        end else if (frame_start) begin
            pend_valid  <= 1'b0;
        end
    end

    assert_cmd_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> pend_valid);
    assert_pend_start_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !pend_stop) |-> (pend_count != '0));
endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import ctx_seq_pkg::*;
#(
    parameter int NUM_CTX = 3,
    parameter int CTX_W   = 2,
    parameter int CNT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pend_valid,
    input  logic             pend_stop,
    input  logic [CNT_W-1:0] pend_count,
    input  logic             pend_repeat,
    output logic [CTX_W-1:0] ctx_q,
    output logic [CTX_W-1:0] ctx_nxt,
    output logic             running
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] len_q, len_d;
    logic             rep_q, rep_d;
    logic [CTX_W-1:0] step_idx;
    logic [CNT_W-1:0] last_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            len_q   <= CNT_W'(1);
            rep_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ctx_q   <= ctx_nxt;
            len_q   <= len_d;
            rep_q   <= rep_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        ctx_nxt  = ctx_q;
        len_d    = len_q;
        rep_d    = rep_q;
        last_idx = len_q - CNT_W'(1);
        step_idx = (CNT_W'(ctx_q) == last_idx) ? '0 : ctx_q + CTX_W'(1);
        if (frame_start) begin
            if (pend_valid && pend_stop) begin
                state_d = ST_IDLE;
                ctx_nxt = '0;
            end else if (pend_valid) begin
                len_d   = pend_count;
                rep_d   = pend_repeat;
                ctx_nxt = '0;
                state_d = (!pend_repeat && (pend_count == CNT_W'(1))) ? ST_HOLD : ST_RUN;
            end else begin
                unique case (state_q)
                    ST_IDLE: ctx_nxt = '0;
                    ST_HOLD: ctx_nxt = ctx_q;
                    ST_RUN: begin
                        ctx_nxt = step_idx;
                        state_d = (!rep_q && (CNT_W'(step_idx) == last_idx)) ? ST_HOLD : ST_RUN;
                    end
                    default: begin
                        state_d = ST_IDLE;
                        ctx_nxt = '0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  running = 1'b1;
            ST_IDLE: running = 1'b0;
            ST_HOLD: running = 1'b0;
            default: running = 1'b0;
        endcase
    end

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q < CTX_W'(NUM_CTX));
    assert_ctx_frame_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ctx_q));
    assert_stop_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && pend_valid && pend_stop) |=> (ctx_q == '0 && !running));
    assert_start_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && pend_valid && !pend_stop) |=> (ctx_q == '0));
    assert_hold_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !pend_valid && state_q == ST_HOLD) |=> $stable(ctx_q));
    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (ctx_q == '0));
endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer #(
    parameter int NUM_CTX    = 3,
    parameter int NUM_FIELDS = 4,
    parameter int FIELD_W    = 16,
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int CNT_W     = $clog2(NUM_CTX + 1),
    localparam int FLD_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
    localparam int PAR_W     = NUM_FIELDS * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               wr_en,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic [FLD_W-1:0]   wr_field,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               cmd_valid,
    input  logic               cmd_stop,
    input  logic [CNT_W-1:0]   cmd_count,
    input  logic               cmd_repeat,
    output logic [PAR_W-1:0]   active_params,
    output logic [CTX_W-1:0]   active_ctx,
    output logic               seq_running
);
    logic             pend_valid, pend_stop, pend_repeat;
    logic [CNT_W-1:0] pend_count;
    logic [CTX_W-1:0] ctx_nxt;
    logic [PAR_W-1:0] bank_rd;

    ctx_cmd_latch #(.NUM_CTX(NUM_CTX), .CNT_W(CNT_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cmd_valid(cmd_valid), .cmd_stop(cmd_stop),
        .cmd_count(cmd_count), .cmd_repeat(cmd_repeat),
        .pend_valid(pend_valid), .pend_stop(pend_stop),
        .pend_count(pend_count), .pend_repeat(pend_repeat)
    );

    ctx_seq_fsm #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pend_valid(pend_valid), .pend_stop(pend_stop),
        .pend_count(pend_count), .pend_repeat(pend_repeat),
        .ctx_q(active_ctx), .ctx_nxt(ctx_nxt), .running(seq_running)
    );

    ctx_bank_store #(
        .NUM_CTX(NUM_CTX), .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W),
        .CTX_W(CTX_W), .FLD_W(FLD_W)
    ) u_banks (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctx(wr_ctx),
        .wr_field(wr_field), .wr_data(wr_data),
        .rd_ctx(ctx_nxt), .rd_params(bank_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)           active_params <= '0;
        else if (frame_start) active_params <= bank_rd;
    end

    assert_params_frame_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active_params));
    assert_load_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (active_params == $past(bank_rd)));
endmodule

// File: tb/ctx_sequencer_tb.sv
`timescale 1ns/1ps
module ctx_sequencer_tb;
    localparam int NC = 3, NF = 4, FW = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        frame_start = 0, wr_en = 0, cmd_valid = 0, cmd_stop = 0, cmd_repeat = 0;
    logic [1:0]  wr_ctx = 0, wr_field = 0, cmd_count = 0;
    logic [15:0] wr_data = 0;
    logic [63:0] active_params;
    logic [1:0]  active_ctx;
    logic        seq_running;

    int n_tests = 0, n_fail = 0;

    logic [15:0] m_bank [4][4];
    int m_ctx, m_st, m_len, p_len;
    bit m_rep, p_valid, p_stop, p_rep;
    logic [63:0] m_act;

    always #4 clk = ~clk;

    ctx_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_field(wr_field), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_stop(cmd_stop), .cmd_count(cmd_count),
        .cmd_repeat(cmd_repeat), .active_params(active_params),
        .active_ctx(active_ctx), .seq_running(seq_running)
    );

    function automatic logic [63:0] bank_vec(int c);
        logic [63:0] v;
        for (int f = 0; f < NF; f++) v[f*FW +: FW] = m_bank[c][f];
        return v;
    endfunction

    function automatic logic [15:0] pattern(int c, int f, int k);
        return 16'((c << 12) | (f << 8) | (k & 8'hFF));
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic mdl_reset();
        for (int c = 0; c < 4; c++) for (int f = 0; f < 4; f++) m_bank[c][f] = '0;
        m_ctx = 0; m_st = 0; m_len = 1; m_rep = 0;
        p_valid = 0; p_stop = 0; p_len = 0; p_rep = 0; m_act = '0;
    endtask

    task automatic mdl_tick();
        if (frame_start) begin
            if (p_valid && p_stop) begin
                m_ctx = 0; m_st = 0;
            end else if (p_valid) begin
                m_len = p_len; m_rep = p_rep; m_ctx = 0;
                m_st = (!m_rep && m_len == 1) ? 2 : 1;
            end else if (m_st == 1) begin
                m_ctx = (m_ctx == m_len - 1) ? 0 : m_ctx + 1;
                if (!m_rep && m_ctx == m_len - 1) m_st = 2;
            end
            m_act = bank_vec(m_ctx);
        end
        if (wr_en && wr_ctx < NC) m_bank[wr_ctx][wr_field] = wr_data;
        if (cmd_valid && (cmd_stop || (cmd_count >= 1 && cmd_count <= NC))) begin
            p_valid = 1; p_stop = cmd_stop; p_len = cmd_count; p_rep = cmd_repeat;
        end else if (frame_start) begin
            p_valid = 0;
        end
    endtask

    // drive inputs at negedge, advance one edge, update model, sample at next negedge
    task automatic tick(bit fs, bit we, int wc, int wf, int wd,
                        bit cv, bit cs, int cc, bit cr);
        frame_start = fs; wr_en = we; wr_ctx = 2'(wc); wr_field = 2'(wf);
        wr_data = 16'(wd); cmd_valid = cv; cmd_stop = cs; cmd_count = 2'(cc);
        cmd_repeat = cr;
        @(posedge clk);
        mdl_tick();
        @(negedge clk);
        frame_start = 0; wr_en = 0; cmd_valid = 0;
    endtask

    task automatic fs_only();
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic chk_model(string tag);
        chk({tag, " ctx"}, 64'(active_ctx), 64'(m_ctx));
        chk({tag, " params"}, active_params, m_act);
        chk({tag, " running"}, 64'(seq_running), 64'(m_st == 1));
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [63:0] snap;
        seed = $urandom(32'd20240607);
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctx", 64'(active_ctx), 64'd0);
        chk("R1 params", active_params, 64'd0);
        chk("R1 running", 64'(seq_running), 64'd0);

        // R2 fill banks, plus an out-of-range write
        for (int c = 0; c < NC; c++)
            for (int f = 0; f < NF; f++)
                tick(0, 1, c, f, pattern(c, f, 1), 0, 0, 0, 0);
        tick(0, 1, 3, 0, 16'hDEAD, 0, 0, 0, 0);
        chk("R3 no load without frame_start", active_params, 64'd0);
        fs_only();
        chk("R12 idle reload ctx0", active_params, bank_vec(0));
        chk("R12 idle ctx", 64'(active_ctx), 64'd0);

        // R5 start 3 contexts, repeat; latched mid-frame
        tick(0, 0, 0, 0, 0, 1, 0, 3, 1);
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 waits for frame ctx", 64'(active_ctx), 64'd0);
        chk("R5 waits for frame running", 64'(seq_running), 64'd0);
        fs_only();
        chk("R5 first ctx", 64'(active_ctx), 64'd0);
        chk("R10 running", 64'(seq_running), 64'd1);
        fs_only();
        chk("R6 step ctx1", 64'(active_ctx), 64'd1);
        chk("R6 ctx1 params", active_params, bank_vec(1));
        fs_only();
        chk("R6 step ctx2", 64'(active_ctx), 64'd2);
        chk("R2 bank2 field3", 64'(active_params[63:48]), 64'(pattern(2, 3, 1)));
        // R4 write to active bank: shadowed
        snap = active_params;
        tick(0, 1, 2, 1, 16'hBEEF, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 shadowed write", active_params, snap);
        fs_only();
        chk("R7 wrap ctx0", 64'(active_ctx), 64'd0);
        chk("R7 still running", 64'(seq_running), 64'd1);
        fs_only(); fs_only();
        chk("R4 written bank now visible", 64'(active_params[31:16]), 64'h0000BEEF);

        // R2 out-of-range write touched no bank: bank0 intact
        fs_only();
        chk("R2 ignored wr_ctx=3 ctx", 64'(active_ctx), 64'd0);
        chk("R2 ignored wr_ctx=3 bank0", active_params, bank_vec(0));
        chk("R2 bank0 field0", 64'(active_params[15:0]), 64'(pattern(0, 0, 1)));

        // R9 stop mid-sequence
        fs_only();
        tick(0, 0, 0, 0, 0, 1, 1, 0, 0);
        chk("R9 stop waits", 64'(active_ctx), 64'd1);
        fs_only();
        chk("R9 stop ctx", 64'(active_ctx), 64'd0);
        chk("R9 stop running", 64'(seq_running), 64'd0);

        // R8 two contexts, no repeat
        tick(0, 0, 0, 0, 0, 1, 0, 2, 0);
        fs_only();
        chk("R10 running ctx0", 64'(seq_running), 64'd1);
        fs_only();
        chk("R8 last ctx", 64'(active_ctx), 64'd1);
        chk("R10 done after last", 64'(seq_running), 64'd0);
        tick(0, 1, 1, 0, 16'h1234, 0, 0, 0, 0);
        fs_only();
        chk("R8 hold ctx", 64'(active_ctx), 64'd1);
        chk("R12 hold reload", 64'(active_params[15:0]), 64'h1234);

        // R5 count of zero ignored
        tick(0, 0, 0, 0, 0, 1, 0, 0, 1);
        fs_only();
        chk("R5 zero count ignored", 64'(active_ctx), 64'd1);
        chk("R5 zero count running", 64'(seq_running), 64'd0);

        // R11 latest of two commands wins
        tick(0, 0, 0, 0, 0, 1, 0, 3, 1);
        tick(0, 0, 0, 0, 0, 1, 0, 1, 0);
        fs_only();
        chk("R11 latest ctx", 64'(active_ctx), 64'd0);
        chk("R11 latest running", 64'(seq_running), 64'd0);
        fs_only();
        chk("R11 latest held", 64'(active_ctx), 64'd0);
        // command in the same cycle as frame_start waits
        tick(1, 0, 0, 0, 0, 1, 0, 2, 1);
        chk("R11 same-cycle waits", 64'(seq_running), 64'd0);
        fs_only();
        chk("R11 same-cycle applied", 64'(seq_running), 64'd1);
        chk_model("R3 directed end");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit fs, we, cv, cs, cr;
            int wc, wf, wd, cc;
            fs = ($urandom % 6) == 0;
            we = ($urandom % 3) == 0;
            wc = $urandom % 4; wf = $urandom % 4; wd = $urandom % 65536;
            cv = ($urandom % 20) == 0;
            cs = ($urandom % 4) == 0;
            cc = $urandom % 4;
            cr = $urandom % 2;
            tick(fs, we, wc, wf, wd, cv, cs, cc, cr);
            chk_model("R3/R6/R7/R8/R10 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule